// File: doc/BRIEF.md
# Legacy Video Aperture Decoder

This block sits between the host memory bus and the video memory controller of a display adapter. It watches each host access in the 20-bit real-mode address space and decides whether the access lands in the legacy graphics window. Such an access becomes a banked video memory address. A small register window can also be overlaid on the region, and accesses there are steered to it instead. A two-bit window select chooses where the legacy window sits and how large it is. A four-bit linear-aperture enable field switches the whole legacy decode off as soon as any of its bits is set.

Video memory addresses are formed from two bank offset registers. The host offset is first masked to the window size. Bit 15 of the masked offset picks one of the two banks. The low 15 bits are then added to the chosen bank value.

Inside the register window, reads are answered directly. The blitter status byte reads as zero, which means the blitter is idle. Every other byte reads as all ones. Word and dword reads are assembled one byte per lane, starting at the addressed offset.

All results are registered and appear one clock after the access is sampled.

Top module: `legacy_aperture_decoder`

## Requirements
- R1: After a synchronous reset, `vram_hit` and `reg_hit` are 0, `reg_rdata` is 0xFFFFFFFF and both bank registers are zero.
- R2: `win_select` places the video window as follows. 0 covers 0xA0000–0xBFFFF, 1 covers 0xA0000–0xAFFFF, 2 covers 0xB0000–0xB7FFF and 3 covers 0xB8000–0xBFFFF. An access inside the selected window raises `vram_hit`.
- R3: The host offset is masked with 0xFFFF for selects 0 and 1, and with 0x7FFF for selects 2 and 3. As a result, the 32 KB windows always use bank 0.
- R4: `vram_addr` equals the low 15 bits of the masked offset plus bank register [bit 15 of the masked offset].
- R5: A bank write (`bank_wr_en`, index `bank_wr_idx`) takes effect at the next clock edge. An access sampled in the same cycle as the write still sees the old bank value.
- R6: `reg_hit` is raised only for addresses 0xB8000–0xB80FF, only when `win_select` is 1 and only when `reg_win_en` is 1. `reg_offset` then carries address bits 7:0.
- R7: When any bit of `lin_ap_en` is set, neither `vram_hit` nor `reg_hit` is raised.
- R8: In the register window, the byte at offset 0x40 reads 0x00 and every other offset reads 0xFF.
- R9: `host_size` selects the access width: 0 is a byte, 1 is a word, and 2 or 3 is a dword. Lane i (`reg_rdata[8i+7:8i]`) carries offset (base + i) mod 256. Lanes beyond the access width read 0xFF. Without a register hit, `reg_rdata` is 0xFFFFFFFF.
- R10: Outputs follow the sampled access by exactly one clock. With `host_valid` low, neither hit flag is raised.
- R11: An address outside the selected window and outside the register window raises neither hit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_select | input | 2 | Legacy window placement and size |
| lin_ap_en | input | 4 | Linear aperture enables; nonzero disables legacy decode |
| reg_win_en | input | 1 | Enable for the register window overlay |
| bank_wr_en | input | 1 | Bank register write strobe |
| bank_wr_idx | input | 1 | Bank register index |
| bank_wr_data | input | 22 | Bank register value |
| host_valid | input | 1 | Host access present |
| host_addr | input | 20 | Host byte address |
| host_size | input | 2 | Access width code |
| vram_hit | output | 1 | Access maps to video memory |
| vram_addr | output | 22 | Translated video memory address |
| reg_hit | output | 1 | Access maps to the register window |
| reg_offset | output | 8 | Register window byte offset |
| reg_rdata | output | 32 | Register window read data |

## Verification
The vector walk tries each window select against addresses just inside and just outside its edges. This separates the four range decodes, and it shows that a 128 KB window folds 0xB8000 onto bank 1 while a 32 KB window keeps it in bank 0. Register-window vectors vary the access width and the start offset around 0x40 and across the 0xFF wrap, which exposes lane ordering mistakes. Cases with the overlay enable cleared, with linear enables set and with the other three selects confirm that the overlay appears only in the 64 KB mode. Directed tests cover the reset state, the same-cycle bank write, and idle cycles.

// File: rtl/lap_pkg.sv
package lap_pkg;
  localparam int HOST_AW = 20;

  typedef enum logic [1:0] {
    WIN_A0_128K = 2'd0,
    WIN_A0_64K  = 2'd1,
    WIN_B0_32K  = 2'd2,
    WIN_B8_32K  = 2'd3
  } win_sel_e;

  localparam logic [HOST_AW-9:0] REG_WIN_PAGE  = 12'hB80;
  localparam logic [7:0]         BLT_STAT_OFF  = 8'h40;
  localparam logic [15:0]        MASK_WIDE     = 16'hFFFF;
  localparam logic [15:0]        MASK_NARROW   = 16'h7FFF;
endpackage

// File: rtl/lap_window_decode.sv
module lap_window_decode
  import lap_pkg::*;
#(
  parameter int LIN_W = 4
) (
  input  win_sel_e             win_sel,
  input  logic [LIN_W-1:0]     lin_en,
  input  logic                 reg_en,
  input  logic [HOST_AW-1:0]   addr,
  output logic                 vram_sel,
  output logic                 reg_sel,
  output logic [15:0]          masked_off
);
  logic legacy_on;
  logic in_win;
  logic [15:0] mask;

  always_comb begin
    legacy_on = (lin_en == '0);
    in_win    = 1'b0;
    mask      = MASK_WIDE;
    case (win_sel)
      WIN_A0_128K: begin in_win = (addr[19:17] == 3'b101);   mask = MASK_WIDE;   end
      WIN_A0_64K:  begin in_win = (addr[19:16] == 4'hA);     mask = MASK_WIDE;   end
      WIN_B0_32K:  begin in_win = (addr[19:15] == 5'b10110); mask = MASK_NARROW; end
      default:     begin in_win = (addr[19:15] == 5'b10111); mask = MASK_NARROW; end
    endcase
    vram_sel   = legacy_on && in_win;
    reg_sel    = legacy_on && reg_en && (win_sel == WIN_A0_64K) &&
                 (addr[HOST_AW-1:8] == REG_WIN_PAGE);
    masked_off = addr[15:0] & mask;
  end
endmodule

// File: rtl/lap_bank_xlate.sv
module lap_bank_xlate #(
  parameter int VRAM_AW = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_idx,
  input  logic [VRAM_AW-1:0] wr_data,
  input  logic [15:0]        masked_off,
  output logic [VRAM_AW-1:0] xaddr
);
  localparam int NBANK  = 2;
  localparam int LOW_W  = 15;

  logic [VRAM_AW-1:0] bank_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                              bank_q[g] <= '0;
      else if (wr_en && (wr_idx == 1'(g)))  bank_q[g] <= wr_data;
    end
  end

  assign xaddr = {{(VRAM_AW-LOW_W){1'b0}}, masked_off[LOW_W-1:0]} + bank_q[masked_off[15]];

  // Shadow of the last write, cleared by reset, for the write check
  logic               prev_we;
  logic               prev_idx;
  logic [VRAM_AW-1:0] prev_data;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_we   <= 1'b0;
      prev_idx  <= 1'b0;
      prev_data <= '0;
    end else begin
      prev_we   <= wr_en;
      prev_idx  <= wr_idx;
      prev_data <= wr_data;
    end
  end

  a_r5_bank_write_lands: assert property (@(posedge clk) disable iff (rst)
    prev_we |-> (bank_q[prev_idx] == prev_data));
endmodule

// File: rtl/lap_reg_responder.sv
module lap_reg_responder
  import lap_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [7:0]         base_off,
  input  logic [1:0]         size,
  output logic [8*LANES-1:0] lanes
);
  logic [2:0] active_n;

  always_comb begin
    case (size)
      2'd0:    active_n = 3'd1;
      2'd1:    active_n = 3'd2;
      default: active_n = 3'd4;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_off;
    assign lane_off = base_off + 8'(i);
    assign lanes[8*i +: 8] = (3'(i) >= active_n)      ? 8'hFF :
                             (lane_off == BLT_STAT_OFF) ? 8'h00 : 8'hFF;
  end
endmodule

// File: rtl/legacy_aperture_decoder.sv
module legacy_aperture_decoder
  import lap_pkg::*;
#(
  parameter int VRAM_AW = 22,
  parameter int LIN_W   = 4,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         win_select,
  input  logic [LIN_W-1:0]   lin_ap_en,
  input  logic               reg_win_en,
  input  logic               bank_wr_en,
  input  logic               bank_wr_idx,
  input  logic [VRAM_AW-1:0] bank_wr_data,
  input  logic               host_valid,
  input  logic [19:0]        host_addr,
  input  logic [1:0]         host_size,
  output logic               vram_hit,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic               reg_hit,
  output logic [7:0]         reg_offset,
  output logic [8*LANES-1:0] reg_rdata
);
  localparam int DW = 8 * LANES;

  win_sel_e           sel;
  logic               vram_sel, reg_sel;
  logic [15:0]        masked_off;
  logic [VRAM_AW-1:0] xaddr;
  logic [DW-1:0]      lane_data;

  assign sel = win_sel_e'(win_select);

  lap_window_decode #(.LIN_W(LIN_W)) u_dec (
    .win_sel(sel), .lin_en(lin_ap_en), .reg_en(reg_win_en), .addr(host_addr),
    .vram_sel(vram_sel), .reg_sel(reg_sel), .masked_off(masked_off));

  lap_bank_xlate #(.VRAM_AW(VRAM_AW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bank_wr_en), .wr_idx(bank_wr_idx),
    .wr_data(bank_wr_data), .masked_off(masked_off), .xaddr(xaddr));

  lap_reg_responder #(.LANES(LANES)) u_resp (
    .base_off(host_addr[7:0]), .size(host_size), .lanes(lane_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      vram_hit   <= 1'b0;
      reg_hit    <= 1'b0;
      vram_addr  <= '0;
      reg_offset <= '0;
      reg_rdata  <= '1;
    end else begin
      vram_hit   <= host_valid && vram_sel;
      reg_hit    <= host_valid && reg_sel;
      vram_addr  <= xaddr;
      reg_offset <= host_addr[7:0];
      reg_rdata  <= (host_valid && reg_sel) ? lane_data : '1;
    end
  end

  a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !$past(host_valid) |-> (!vram_hit && !reg_hit));

  a_r7_linear_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(lin_ap_en) != '0) |-> (!vram_hit && !reg_hit));

  a_r6_reg_only_64k: assert property (@(posedge clk) disable iff (rst)
    reg_hit |-> ($past(win_select) == 2'd1 && $past(reg_win_en)));

  a_r11_hits_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(vram_hit && reg_hit));

  a_r8_status_byte: assert property (@(posedge clk) disable iff (rst)
    (reg_hit && $past(host_size) == 2'd0 && reg_offset == 8'h40) |->
      (reg_rdata == {{(DW-8){1'b1}}, 8'h00}));

  a_r9_no_hit_ones: assert property (@(posedge clk) disable iff (rst)
    !reg_hit |-> (reg_rdata == '1));
endmodule

// File: tb/tb_legacy_aperture_decoder.sv
module tb_legacy_aperture_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  win_select;
  logic [3:0]  lin_ap_en;
  logic        reg_win_en;
  logic        bank_wr_en;
  logic        bank_wr_idx;
  logic [21:0] bank_wr_data;
  logic        host_valid;
  logic [19:0] host_addr;
  logic [1:0]  host_size;
  logic        vram_hit;
  logic [21:0] vram_addr;
  logic        reg_hit;
  logic [7:0]  reg_offset;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  legacy_aperture_decoder dut (
    .clk(clk), .rst(rst), .win_select(win_select), .lin_ap_en(lin_ap_en),
    .reg_win_en(reg_win_en), .bank_wr_en(bank_wr_en), .bank_wr_idx(bank_wr_idx),
    .bank_wr_data(bank_wr_data), .host_valid(host_valid), .host_addr(host_addr),
    .host_size(host_size), .vram_hit(vram_hit), .vram_addr(vram_addr),
    .reg_hit(reg_hit), .reg_offset(reg_offset), .reg_rdata(reg_rdata));

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  lin;
    logic        ren;
    logic [19:0] addr;
    logic [1:0]  size;
    logic        e_vram;
    logic [21:0] e_vaddr;
    logic        e_reg;
    logic [7:0]  e_off;
    logic [31:0] e_rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  // bank0 = 0x010000, bank1 = 0x200000
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'h0, 1'b0, 20'hA1234, 2'd0, 1'b1, 22'h011234, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd4},
    '{2'd0, 4'h0, 1'b0, 20'hA9234, 2'd0, 1'b1, 22'h201234, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd4},
    '{2'd0, 4'h0, 1'b0, 20'hB8010, 2'd0, 1'b1, 22'h200010, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd3},
    '{2'd0, 4'h0, 1'b0, 20'h9FFFF, 2'd0, 1'b0, 22'h000000, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd11},
    '{2'd1, 4'h0, 1'b0, 20'hAFFFF, 2'd0, 1'b1, 22'h207FFF, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd2},
    '{2'd1, 4'h0, 1'b1, 20'hB0000, 2'd0, 1'b0, 22'h000000, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd11},
    '{2'd1, 4'h0, 1'b1, 20'hB8040, 2'd0, 1'b0, 22'h000000, 1'b1, 8'h40, 32'hFFFFFF00, 8'd8},
    '{2'd1, 4'h0, 1'b1, 20'hB803E, 2'd2, 1'b0, 22'h000000, 1'b1, 8'h3E, 32'hFF00FFFF, 8'd9},
    '{2'd1, 4'h0, 1'b1, 20'hB80FF, 2'd1, 1'b0, 22'h000000, 1'b1, 8'hFF, 32'hFFFFFFFF, 8'd9},
    '{2'd1, 4'h0, 1'b1, 20'hB803F, 2'd1, 1'b0, 22'h000000, 1'b1, 8'h3F, 32'hFFFF00FF, 8'd9},
    '{2'd1, 4'h0, 1'b1, 20'hB80C1, 2'd3, 1'b0, 22'h000000, 1'b1, 8'hC1, 32'hFFFFFFFF, 8'd8},
    '{2'd1, 4'h0, 1'b0, 20'hB8040, 2'd0, 1'b0, 22'h000000, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd6},
    '{2'd2, 4'h0, 1'b0, 20'hB4321, 2'd0, 1'b1, 22'h014321, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd3},
    '{2'd2, 4'h0, 1'b1, 20'hB8000, 2'd0, 1'b0, 22'h000000, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd11},
    '{2'd3, 4'h0, 1'b0, 20'hBC321, 2'd0, 1'b1, 22'h014321, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd3},
    '{2'd3, 4'h0, 1'b1, 20'hB8040, 2'd0, 1'b1, 22'h010040, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd6},
    '{2'd0, 4'h1, 1'b0, 20'hA1234, 2'd0, 1'b0, 22'h000000, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd7},
    '{2'd1, 4'h8, 1'b1, 20'hB8040, 2'd0, 1'b0, 22'h000000, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] m, input logic [3:0] l, input logic r,
                        input logic [19:0] a, input logic [1:0] s);
    win_select = m; lin_ap_en = l; reg_win_en = r;
    host_addr = a; host_size = s; host_valid = 1'b1;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic wr_bank(input logic idx, input logic [21:0] d);
    bank_wr_en = 1'b1; bank_wr_idx = idx; bank_wr_data = d;
    @(negedge clk);
    bank_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; win_select = 2'd0; lin_ap_en = 4'h0; reg_win_en = 1'b0;
    bank_wr_en = 1'b0; bank_wr_idx = 1'b0; bank_wr_data = '0;
    host_valid = 1'b0; host_addr = '0; host_size = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 vram_hit", {31'd0, vram_hit}, 32'd0);
    check("R1 reg_hit", {31'd0, reg_hit}, 32'd0);
    check("R1 reg_rdata", reg_rdata, 32'hFFFFFFFF);
    rst = 1'b0;
    @(negedge clk);
    // R1 banks zero: A1234 in mode 0 -> 0x1234
    access(2'd0, 4'h0, 1'b0, 20'hA1234, 2'd0);
    check("R1 bank0 zero", {10'd0, vram_addr}, 32'h00001234);

    wr_bank(1'b0, 22'h010000);
    wr_bank(1'b1, 22'h200000);

    // Vector walk: R2 R3 R4 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].mode, VEC[i].lin, VEC[i].ren, VEC[i].addr, VEC[i].size);
      check($sformatf("R%0d vec%0d vram_hit", VEC[i].req, i), {31'd0, vram_hit}, {31'd0, VEC[i].e_vram});
      check($sformatf("R%0d vec%0d reg_hit", VEC[i].req, i), {31'd0, reg_hit}, {31'd0, VEC[i].e_reg});
      check($sformatf("R%0d vec%0d reg_rdata", VEC[i].req, i), reg_rdata, VEC[i].e_rdata);
      if (VEC[i].e_vram)
        check($sformatf("R%0d vec%0d vram_addr", VEC[i].req, i), {10'd0, vram_addr}, {10'd0, VEC[i].e_vaddr});
      if (VEC[i].e_reg)
        check($sformatf("R%0d vec%0d reg_offset", VEC[i].req, i), {24'd0, reg_offset}, {24'd0, VEC[i].e_off});
    end

    // R5: write bank1 and access in the same cycle -> old value
    bank_wr_en = 1'b1; bank_wr_idx = 1'b1; bank_wr_data = 22'h300000;
    access(2'd0, 4'h0, 1'b0, 20'hA8005, 2'd0);
    bank_wr_en = 1'b0;
    check("R5 same-cycle old bank", {10'd0, vram_addr}, 32'h00200005);
    access(2'd0, 4'h0, 1'b0, 20'hA8005, 2'd0);
    check("R5 new bank visible", {10'd0, vram_addr}, 32'h00300005);

    // R3: 32K window never uses bank1
    access(2'd3, 4'h0, 1'b0, 20'hBFFFF, 2'd0);
    check("R3 narrow uses bank0", {10'd0, vram_addr}, 32'h00017FFF);

    // R10: valid low -> no hits; latency one cycle
    win_select = 2'd1; reg_win_en = 1'b1; host_addr = 20'hB8040; host_valid = 1'b0;
    @(negedge clk);
    check("R10 idle reg_hit", {31'd0, reg_hit}, 32'd0);
    check("R10 idle vram_hit", {31'd0, vram_hit}, 32'd0);
    host_valid = 1'b1;
    @(posedge clk); #1;
    check("R10 one-cycle latency", {31'd0, reg_hit}, 32'd1);
    host_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 drops after valid low", {31'd0, reg_hit}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule